// File: doc/BRIEF.md
# System Reset and Boot Controller

This block merges every reset source of the chip into one system reset. The sources are an external active-low reset pin, a one-cycle timeout pulse from the watchdog, and two self-clearing software-reset bits in a mode register. Every reset is stretched to a fixed length. On the edge where the system reset deasserts, the block samples the boot strap once and holds the result until the next reset.

The pin passes through a synchronizer and a minimum-width filter, so a short glitch on the board does not reset the chip. Of the two software-reset bits, one leaves the address remap flag low after the reset and the other leaves it high. The block also drives a reset for a coprocessor. That reset is asserted by every system reset and stays asserted until software clears it. Software must set and clear it three times before inter-processor messaging is treated as synchronized. A cause register records which source produced the last reset. Only power-on clears it.

Top module: `rstboot_ctrl`

## Requirements
- R1: If `ext_rst_n` is sampled low on 10 consecutive rising edges, `sys_rst_n` goes low just after the 12th edge counted from the first of those samples. A low run of 9 samples or fewer causes no reset.
- R2: A one-cycle `wdt_tmo` pulse makes `sys_rst_n` low just after the edge that samples it, and clears `remap`.
- R3: An accepted mode write with bit 11 set starts a software reset, and `remap` is 0 afterwards.
- R4: An accepted mode write with bit 10 set and bit 11 clear starts a software reset, and `remap` is 1 afterwards.
- R5: A write with both bit 11 and bit 10 set acts as bit 11 alone, so `remap` is 0.
- R6: `boot_ext` loads `boot_strap` on the edge where `sys_rst_n` rises and ignores the strap at all other times.
- R7: After the last edge that saw a reset request, `sys_rst_n` stays low for exactly 16 cycles. It is also low for 16 cycles after power-on (`por_n`).
- R8: `cop_rst` is 1 whenever `sys_rst_n` is low. After a reset it stays 1 until an accepted mode write puts 0 in bit 2, which is its control bit.
- R9: A complete pulse is a software write that sets bit 2 followed by one that clears it. The count of complete pulses reads in bits 5:4 and saturates at 3. `cop_sync` and bit 3 are 1 once the count is 3. Releasing the reset-forced coprocessor reset adds no count, and any system reset clears the count.
- R10: `mode_rdata` reads remap in bit 0, boot_ext in bit 1, cop_rst in bit 2, cop_sync in bit 3, the pulse count in bits 5:4, and zero in every other bit, including the software-reset bits 11:10.
- R11: `cause` reads 00 after power-on, 01 after a pin reset, 10 after a watchdog reset and 11 after a software reset. When several sources request in one cycle, the pin wins over the watchdog and the watchdog wins over software. Only `por_n` clears the register.
- R12: Mode writes made while `sys_rst_n` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous to clk |
| wdt_tmo | input | 1 | Watchdog timeout, one-cycle pulse |
| boot_strap | input | 1 | Boot source strap: 1 = external memory on chip select 0, 0 = internal ROM |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 16 | Mode register write data |
| mode_rdata | output | 16 | Mode register read value |
| cause | output | 2 | Cause of the last reset |
| sys_rst_n | output | 1 | Chip-wide reset, active low |
| remap | output | 1 | Latched address remap flag |
| boot_ext | output | 1 | Latched boot source flag |
| cop_rst | output | 1 | Coprocessor reset, active high |
| cop_sync | output | 1 | Set after three complete coprocessor reset pulses |

## Verification
Mode writes and watchdog pulses take effect on the edge that samples them, so their results are checked at the falling edge that follows. A pin reset appears only after two synchronizer stages and a ten-sample run, so the bench checks that the reset is still absent at the eleventh falling edge and present at the twelfth. The release comes 16 edges after the last request, and the boot flag is loaded on that same edge. A behavioural model advances on each rising edge, and every output is compared with it at each falling edge, away from the edges where the design's registers change.

// File: rtl/rstboot_pkg.sv
package rstboot_pkg;

  localparam int MODE_W = 16;

  // mode register field positions
  localparam int MB_REMAP   = 0;
  localparam int MB_BOOT    = 1;
  localparam int MB_COP     = 2;
  localparam int MB_SYNC    = 3;
  localparam int MB_CNT     = 4;
  localparam int MB_SWR_HI  = 10; // software reset, remap set afterwards
  localparam int MB_SWR_LO  = 11; // software reset, remap clear afterwards

  typedef enum logic [1:0] {
    CAUSE_POR = 2'b00,
    CAUSE_PIN = 2'b01,
    CAUSE_WDT = 2'b10,
    CAUSE_SW  = 2'b11
  } rst_cause_e;

endpackage

// File: rtl/rstboot_pin_filter.sv
module rstboot_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_W       = 10
) (
  input  logic clk,
  input  logic por_n,
  input  logic ext_rst_n,
  output logic pin_req
);

  localparam int RW = (MIN_W > 1) ? $clog2(MIN_W) : 1;
  localparam logic [RW-1:0] RUN_MAX = RW'(MIN_W - 1);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [RW-1:0]          run_q, run_d;
  logic                   pin_low;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      assign sync_d = ext_rst_n;
    end else begin : g_chain
      assign sync_d = {sync_q[SYNC_STAGES-2:0], ext_rst_n};
    end
  endgenerate

  assign pin_low = ~sync_q[SYNC_STAGES-1];

  always_comb begin
    run_d = run_q;
    if (!pin_low) begin
      run_d = '0;
    end else if (run_q != RUN_MAX) begin
      run_d = run_q + 1'b1;
    end
  end

  assign pin_req = pin_low && (run_q == RUN_MAX);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sync_q <= '1;
      run_q  <= '0;
    end else begin
      sync_q <= sync_d;
      run_q  <= run_d;
    end
  end

  generate
    if (MIN_W > 1) begin : g_chk
      AST_PIN_NOT_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
        pin_req |-> $past(pin_low)); // R1
    end
  endgenerate

endmodule

// File: rtl/rstboot_stretch.sv
module rstboot_stretch #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic req,
  output logic busy,
  output logic release_now
);

  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  always_comb begin
    cnt_d = cnt_q;
    if (req) begin
      cnt_d = HOLD_V;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
    busy_d = (cnt_d != '0);
  end

  assign release_now = busy_q && !busy_d;
  assign busy        = busy_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q  <= HOLD_V;
      busy_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  AST_NO_RELEASE_ON_REQ: assert property (@(posedge clk) disable iff (!por_n)
    $fell(busy_q) |-> !$past(req)); // R7

endmodule

// File: rtl/rstboot_cop_ctrl.sv
module rstboot_cop_ctrl #(
  parameter int PULSES = 3
) (
  input  logic                          clk,
  input  logic                          por_n,
  input  logic                          force_rst,
  input  logic                          wr_en,
  input  logic                          wr_val,
  output logic                          cop_rst,
  output logic [$clog2(PULSES+1)-1:0]   pulse_cnt,
  output logic                          sync_done
);

  localparam int PW = $clog2(PULSES + 1);
  localparam logic [PW-1:0] PMAX = PW'(PULSES);

  logic          cop_q, cop_d;
  logic          armed_q, armed_d;
  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    cop_d   = cop_q;
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (force_rst) begin
      cop_d   = 1'b1;
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (wr_en) begin
      cop_d = wr_val;
      if (!cop_q && wr_val) begin
        armed_d = 1'b1;
      end
      if (cop_q && !wr_val && armed_q) begin
        armed_d = 1'b0;
        if (cnt_q != PMAX) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cop_q   <= 1'b1;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      cop_q   <= cop_d;
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  assign cop_rst   = cop_q;
  assign pulse_cnt = cnt_q;
  assign sync_done = (cnt_q == PMAX);

  AST_COP_HELD_BY_RST: assert property (@(posedge clk) disable iff (!por_n)
    force_rst |=> cop_q); // R8
  AST_SYNC_ON_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sync_done) |-> $fell(cop_q)); // R9

endmodule

// File: rtl/rstboot_ctrl.sv
module rstboot_ctrl
  import rstboot_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PIN_MIN     = 10,
  parameter int HOLD        = 16,
  parameter int COP_PULSES  = 3
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ext_rst_n,
  input  logic              wdt_tmo,
  input  logic              boot_strap,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  output logic [MODE_W-1:0] mode_rdata,
  output logic [1:0]        cause,
  output logic              sys_rst_n,
  output logic              remap,
  output logic              boot_ext,
  output logic              cop_rst,
  output logic              cop_sync
);

  localparam int PW = $clog2(COP_PULSES + 1);

  logic          pin_req, rst_q, release_now;
  logic          sw_lo, sw_hi, sw_req, any_req;
  logic          cop_force, cop_we, cop_q, sync_w;
  logic [PW-1:0] pulse_cnt;
  rst_cause_e    cause_q, cause_d;
  logic          remap_q, remap_d, boot_q, boot_d;
  logic          unused_wdata;

  assign unused_wdata = ^{mode_wdata[15:12], mode_wdata[9:3], mode_wdata[1:0]};

  rstboot_pin_filter #(
    .SYNC_STAGES (SYNC_STAGES),
    .MIN_W       (PIN_MIN)
  ) u_pin (
    .clk       (clk),
    .por_n     (por_n),
    .ext_rst_n (ext_rst_n),
    .pin_req   (pin_req)
  );

  // software requests are accepted only outside reset
  assign sw_lo   = mode_we && !rst_q && mode_wdata[MB_SWR_LO];
  assign sw_hi   = mode_we && !rst_q && mode_wdata[MB_SWR_HI];
  assign sw_req  = sw_lo || sw_hi;
  assign any_req = pin_req || wdt_tmo || sw_req;

  rstboot_stretch #(
    .HOLD (HOLD)
  ) u_stretch (
    .clk         (clk),
    .por_n       (por_n),
    .req         (any_req),
    .busy        (rst_q),
    .release_now (release_now)
  );

  assign cop_force = rst_q || any_req;
  assign cop_we    = mode_we && !rst_q;

  rstboot_cop_ctrl #(
    .PULSES (COP_PULSES)
  ) u_cop (
    .clk       (clk),
    .por_n     (por_n),
    .force_rst (cop_force),
    .wr_en     (cop_we),
    .wr_val    (mode_wdata[MB_COP]),
    .cop_rst   (cop_q),
    .pulse_cnt (pulse_cnt),
    .sync_done (sync_w)
  );

  always_comb begin
    cause_d = cause_q;
    remap_d = remap_q;
    boot_d  = boot_q;
    if (pin_req) begin
      cause_d = CAUSE_PIN;
      remap_d = 1'b0;
    end else if (wdt_tmo) begin
      cause_d = CAUSE_WDT;
      remap_d = 1'b0;
    end else if (sw_req) begin
      cause_d = CAUSE_SW;
      remap_d = !sw_lo;
    end
    if (release_now) begin
      boot_d = boot_strap;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cause_q <= CAUSE_POR;
      remap_q <= 1'b0;
      boot_q  <= 1'b0;
    end else begin
      cause_q <= cause_d;
      remap_q <= remap_d;
      boot_q  <= boot_d;
    end
  end

  always_comb begin
    mode_rdata                  = '0;
    mode_rdata[MB_REMAP]        = remap_q;
    mode_rdata[MB_BOOT]         = boot_q;
    mode_rdata[MB_COP]          = cop_q;
    mode_rdata[MB_SYNC]         = sync_w;
    mode_rdata[MB_CNT +: PW]    = pulse_cnt;
  end

  assign cause     = cause_q;
  assign sys_rst_n = !rst_q;
  assign remap     = remap_q;
  assign boot_ext  = boot_q;
  assign cop_rst   = cop_q;
  assign cop_sync  = sync_w;

  AST_WDT_FORCES_RST: assert property (@(posedge clk) disable iff (!por_n)
    wdt_tmo |=> !sys_rst_n); // R2
  AST_SWR_REMAP_LOW: assert property (@(posedge clk) disable iff (!por_n)
    (mode_we && !rst_q && mode_wdata[MB_SWR_LO]) |=> (!remap && !sys_rst_n)); // R3
  AST_REMAP_RISE_SRC: assert property (@(posedge clk) disable iff (!por_n)
    $rose(remap) |-> $past(mode_we && mode_wdata[MB_SWR_HI] && !mode_wdata[MB_SWR_LO])); // R4
  AST_BOOT_AT_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(boot_ext) |-> $rose(sys_rst_n)); // R6
  AST_CAUSE_WITH_RST: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(cause) |-> !sys_rst_n); // R11

endmodule

// File: tb/tb_rstboot_ctrl.sv
`timescale 1ns/1ps
module tb_rstboot_ctrl;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        ext_rst_n = 1'b1;
  logic        wdt_tmo = 1'b0;
  logic        boot_strap = 1'b1;
  logic        mode_we = 1'b0;
  logic [15:0] mode_wdata = 16'h0;
  logic [15:0] mode_rdata;
  logic [1:0]  cause;
  logic        sys_rst_n, remap, boot_ext, cop_rst, cop_sync;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  rstboot_ctrl dut (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .wdt_tmo(wdt_tmo),
    .boot_strap(boot_strap), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .mode_rdata(mode_rdata), .cause(cause), .sys_rst_n(sys_rst_n),
    .remap(remap), .boot_ext(boot_ext), .cop_rst(cop_rst), .cop_sync(cop_sync)
  );

  // behavioural reference model
  int m_pipe[$];
  int m_run, m_left, m_pulses, m_cause;
  bit m_inrst, m_remap, m_boot, m_cop, m_armed;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_pipe = '{1, 1};
      m_run = 0; m_left = 16; m_inrst = 1; m_remap = 0; m_boot = 0;
      m_cop = 1; m_armed = 0; m_pulses = 0; m_cause = 0;
    end else begin
      bit pin, wd, swl, swh, any, was;
      int seen;
      seen = m_pipe[1];
      pin = (seen == 0) && (m_run >= 9);
      wd  = wdt_tmo;
      swl = mode_we && !m_inrst && mode_wdata[11];
      swh = mode_we && !m_inrst && mode_wdata[10];
      any = pin || wd || swl || swh;
      was = m_inrst;
      if (pin) begin m_cause = 1; m_remap = 0; end
      else if (wd) begin m_cause = 2; m_remap = 0; end
      else if (swl) begin m_cause = 3; m_remap = 0; end
      else if (swh) begin m_cause = 3; m_remap = 1; end
      if (any || was) begin
        m_cop = 1; m_armed = 0; m_pulses = 0;
      end else if (mode_we) begin
        if (!m_cop && mode_wdata[2]) m_armed = 1;
        if (m_cop && !mode_wdata[2] && m_armed) begin
          m_armed = 0;
          if (m_pulses < 3) m_pulses++;
        end
        m_cop = mode_wdata[2];
      end
      if (any) m_left = 16;
      else if (m_left > 0) m_left--;
      m_inrst = (m_left > 0);
      if (was && !m_inrst) m_boot = boot_strap;
      m_run = (seen == 0) ? ((m_run < 9) ? m_run + 1 : 9) : 0;
      void'(m_pipe.pop_back());
      m_pipe.push_front(int'(ext_rst_n));
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (por_n && !done) begin
      int mm;
      mm = int'(m_remap) | (int'(m_boot) << 1) | (int'(m_cop) << 2) |
           (int'(m_pulses == 3) << 3) | (m_pulses << 4);
      chk("R7 model sys_rst_n", {31'b0, sys_rst_n}, {31'b0, !m_inrst});
      chk("R3 model remap",     {31'b0, remap},     {31'b0, m_remap});
      chk("R6 model boot_ext",  {31'b0, boot_ext},  {31'b0, m_boot});
      chk("R8 model cop_rst",   {31'b0, cop_rst},   {31'b0, m_cop});
      chk("R9 model cop_sync",  {31'b0, cop_sync},  {31'b0, m_pulses == 3});
      chk("R10 model mode_rdata", {16'b0, mode_rdata}, mm);
      chk("R11 model cause",    {30'b0, cause},     m_cause);
    end
  end

  task automatic wr(input logic [15:0] d);
    mode_we = 1'b1; mode_wdata = d;
    @(negedge clk);
    mode_we = 1'b0; mode_wdata = 16'h0;
  endtask

  task automatic wait_high();
    int k = 0;
    while (!sys_rst_n && k < 100) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    bit quiet;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    // reset state
    chk("R7 reset sys_rst_n", {31'b0, sys_rst_n}, 0);
    chk("R8 reset cop_rst", {31'b0, cop_rst}, 1);
    chk("R11 reset cause", {30'b0, cause}, 0);
    chk("R10 reset mode_rdata", {16'b0, mode_rdata}, 32'h4);
    wait_high();
    chk("R6 strap sampled", {31'b0, boot_ext}, 1);
    boot_strap = 1'b0;
    repeat (5) @(negedge clk);
    chk("R6 strap ignored", {31'b0, boot_ext}, 1);
    // coprocessor reset handling
    wr(16'h0000);
    chk("R8 cop released", {31'b0, cop_rst}, 0);
    chk("R9 forced release not counted", {16'b0, mode_rdata}, 32'h2);
    for (int i = 0; i < 3; i++) begin
      wr(16'h0004);
      wr(16'h0000);
      if (i == 1) begin
        chk("R9 two pulses", {30'b0, mode_rdata[5:4]}, 2);
        chk("R9 no sync yet", {31'b0, cop_sync}, 0);
      end
    end
    chk("R9 sync after three", {31'b0, cop_sync}, 1);
    chk("R10 readback layout", {16'b0, mode_rdata}, 32'h3A);
    wr(16'h0004); wr(16'h0000);
    chk("R9 count saturates", {30'b0, mode_rdata[5:4]}, 3);
    // software reset, remap high
    wr(16'h0400);
    chk("R4 sw reset asserted", {31'b0, sys_rst_n}, 0);
    chk("R4 remap high", {31'b0, remap}, 1);
    chk("R11 cause sw", {30'b0, cause}, 3);
    chk("R8 cop forced", {31'b0, cop_rst}, 1);
    chk("R9 sync cleared", {31'b0, cop_sync}, 0);
    chk("R10 sw bits read zero", {30'b0, mode_rdata[11:10]}, 0);
    wr(16'h0800);
    chk("R12 write in reset ignored", {31'b0, remap}, 1);
    n = 2;
    forever begin
      @(negedge clk);
      if (sys_rst_n) break;
      n++;
    end
    chk("R7 stretch length", n, 16);
    chk("R6 strap resampled", {31'b0, boot_ext}, 0);
    chk("R8 cop held after reset", {31'b0, cop_rst}, 1);
    // both software bits
    wr(16'h0C00);
    chk("R5 both bits reset", {31'b0, sys_rst_n}, 0);
    chk("R5 bit11 wins", {31'b0, remap}, 0);
    wait_high();
    wr(16'h0400);
    wait_high();
    chk("R4 remap set again", {31'b0, remap}, 1);
    // watchdog
    wdt_tmo = 1'b1;
    @(negedge clk);
    wdt_tmo = 1'b0;
    chk("R2 wdt reset", {31'b0, sys_rst_n}, 0);
    chk("R2 wdt clears remap", {31'b0, remap}, 0);
    chk("R11 cause wdt", {30'b0, cause}, 2);
    wait_high();
    chk("R11 cause kept", {30'b0, cause}, 2);
    // short pin pulse
    ext_rst_n = 1'b0;
    repeat (9) @(negedge clk);
    ext_rst_n = 1'b1;
    quiet = 1'b1;
    repeat (15) begin
      @(negedge clk);
      if (!sys_rst_n) quiet = 1'b0;
    end
    chk("R1 short pin ignored", {31'b0, quiet}, 1);
    chk("R11 cause unchanged", {30'b0, cause}, 2);
    // exactly ten samples
    ext_rst_n = 1'b0;
    repeat (10) @(negedge clk);
    ext_rst_n = 1'b1;
    @(negedge clk);
    chk("R1 not before 12th edge", {31'b0, sys_rst_n}, 1);
    @(negedge clk);
    chk("R1 reset at 12th edge", {31'b0, sys_rst_n}, 0);
    chk("R11 cause pin", {30'b0, cause}, 1);
    wait_high();
    // pin priority over watchdog
    ext_rst_n = 1'b0;
    repeat (12) @(negedge clk);
    chk("R1 long pin reset", {31'b0, sys_rst_n}, 0);
    wdt_tmo = 1'b1;
    @(negedge clk);
    wdt_tmo = 1'b0;
    chk("R11 pin beats wdt", {30'b0, cause}, 1);
    ext_rst_n = 1'b1;
    wait_high();
    chk("R11 cause pin kept", {30'b0, cause}, 1);
    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule